// File: doc/BRIEF.md
# Coprocessor Command Register with Busy Flag

This block is the host-facing command register of a communications coprocessor. The host writes one 16-bit word that carries an opcode, a channel number, a reset request and a busy flag set to 1. If the word is well formed and no earlier command is still running, the block stores it and raises the busy flag. It then either hands the command to one channel engine or reinitializes every engine. The host finds out that the command has finished by polling the flag until it reads 0.

An ordinary command produces a one-cycle dispatch strobe. The strobe carries the opcode and a one-hot selection of the target engine. The block then waits for a done pulse from that engine. A reset command drives a reset level to all engines for a fixed number of cycles instead. The host gives up after a bounded number of polls, so the block also ends a command on its own: if the engine has not answered within a parameterized number of cycles, the busy flag clears anyway.

Field layout of the written word:
- bits [15:8]: opcode
- bits [7:4]: channel number
- bits [3:2]: reserved, must be 0
- bit 1: reset request
- bit 0: busy flag

Top module: `cmdreg_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `rd_data` = 0, `disp_valid` = 0 and `ch_reset` = 0.
- R2: A write is accepted when all of the following hold:
  - bit 0 = 1;
  - bits [3:2] = 0;
  - the flag is clear;
  - either bit 1 = 1, or the channel in bits [7:4] is below `NUM_CH`.

  In the cycle after the accepting edge, `rd_data` equals the written word, with bit 0 reading 1.
- R3: In the cycle after an accepted non-reset write, `disp_valid` is 1 for exactly one cycle. During that cycle, `disp_opcode` equals bits [15:8] of the word, and `disp_sel` is one-hot with its set bit at the index given by bits [7:4].
- R4: A done pulse from the selected channel, sampled at an edge while the command runs (including the strobe cycle), clears `rd_data[0]` in the next cycle. The other bits of `rd_data` keep the stored word. A done pulse from any other channel has no effect.
- R5: A write that arrives while the flag reads 1 is ignored. This includes a write in the same cycle as the completing done pulse: no strobe follows, and the stored word is unchanged.
- R6: A write is ignored, with no strobe, no channel reset and `rd_data` unchanged, in each of these cases:
  - it has bit 0 = 0;
  - any of bits [3:2] is set;
  - it is a non-reset write whose channel is `NUM_CH` or above.
- R7: An accepted write with bit 1 = 1 never strobes. Starting the cycle after acceptance, it drives all `ch_reset` bits high for exactly `RST_CYCLES` cycles. The flag clears in the cycle after the last of them. The channel field is not checked for a reset write.
- R8: If no done pulse arrives, the flag clears `MAX_WAIT` cycles after the accepting edge. A following valid write is accepted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the command word |
| wr_data | input | 16 | Command word written by the host |
| rd_data | output | 16 | Stored command word with the live busy flag in bit 0 |
| disp_valid | output | 1 | One-cycle dispatch strobe to the channel engines |
| disp_opcode | output | 8 | Opcode that goes with the dispatch strobe |
| disp_sel | output | NUM_CH | One-hot target engine of the dispatch strobe |
| ch_done | input | NUM_CH | Completion pulse from each engine |
| ch_reset | output | NUM_CH | Reset level driven to every engine during a reset command |

## Verification
Two events can fall in the same clock cycle: a new host write, and the done pulse that completes the running command. The bench raises `wr_en` with a valid word in the very cycle it pulses the selected `ch_done`. It then checks three things: the flag reads 0 in the next cycle, no dispatch strobe follows, and the stored word still holds the finished command. A done pulse given in the strobe cycle itself is also exercised, to confirm that completion and dispatch can overlap.

// File: rtl/cmdreg_pkg.sv
// Shared field positions and sequencer states for the command register.
// Assumes a 16-bit command word with the opcode in the top byte.
package cmdreg_pkg;
    localparam int WORD_W  = 16;
    localparam int OP_LSB  = 8;
    localparam int OP_W    = 8;
    localparam int CH_LSB  = 4;
    localparam int CH_W    = 4;
    localparam int RSV_LSB = 2;
    localparam int RSV_W   = 2;
    localparam int RST_BIT = 1;
    localparam int FLG_BIT = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESET = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cmdreg_decode.sv
// Checks that a written word is a well-formed command.
// Assumes NUM_CH is at most 2**CH_W; a reset word skips the channel check.
module cmdreg_decode
    import cmdreg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [WORD_W-1:0] word,
    output logic              cmd_ok,
    output logic              is_reset
);
    logic [CH_W-1:0] chan;
    logic            chan_ok;
    logic            rsv_clear;

    // Split the word into the fields the validity test needs.
    always_comb begin
        chan      = word[CH_LSB +: CH_W];
        rsv_clear = (word[RSV_LSB +: RSV_W] == '0);
        is_reset  = word[RST_BIT];
        chan_ok   = ({{(32-CH_W){1'b0}}, chan} < NUM_CH);
        cmd_ok    = word[FLG_BIT] && rsv_clear && (is_reset || chan_ok);
    end
endmodule

// File: rtl/cmdreg_seq.sv
// Sequencer for one command: issue, wait for done or timeout, or reset run.
// Assumes accept is only raised while the sequencer is idle.
module cmdreg_seq
    import cmdreg_pkg::*;
#(
    parameter int MAX_WAIT   = 10000,
    parameter int RST_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       is_reset,
    input  logic       done_hit,
    output seq_state_t state,
    output logic       busy
);
    localparam int BIG   = (MAX_WAIT > RST_CYCLES) ? MAX_WAIT : RST_CYCLES;
    localparam int CNT_W = $clog2(BIG + 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(MAX_WAIT - 1);
    localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Advance the command state, the shared cycle counter and the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        busy  <= 1'b1;
                        cnt   <= '0;
                        state <= is_reset ? ST_RESET : ST_ISSUE;
                    end
                end
                ST_ISSUE, ST_WAIT: begin
                    if (done_hit || cnt == WAIT_LAST) begin
                        busy  <= 1'b0;
                        state <= ST_IDLE;
                    end else begin
                        cnt   <= cnt + 1'b1;
                        state <= ST_WAIT;
                    end
                end
                ST_RESET: begin
                    if (cnt == RST_LAST) begin
                        busy  <= 1'b0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmdreg_fanout.sv
// Per-channel fan-out of dispatch select, reset level and done pick-up.
// Assumes chan holds an index below NUM_CH whenever a command is running.
module cmdreg_fanout
    import cmdreg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  seq_state_t        state,
    input  logic [CH_W-1:0]   chan,
    input  logic [NUM_CH-1:0] ch_done,
    output logic [NUM_CH-1:0] disp_sel,
    output logic [NUM_CH-1:0] ch_reset,
    output logic              done_hit
);
    logic              issuing;
    logic              running;
    logic              resetting;
    logic [NUM_CH-1:0] hit;

    // Decode the phases the channel lanes care about.
    always_comb begin
        issuing   = (state == ST_ISSUE);
        running   = (state == ST_ISSUE) || (state == ST_WAIT);
        resetting = (state == ST_RESET);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        logic picked;
        // Drive one lane from the stored channel number.
        always_comb begin
            picked      = (chan == CH_W'(i));
            disp_sel[i] = issuing && picked;
            ch_reset[i] = resetting;
            hit[i]      = running && picked && ch_done[i];
        end
    end

    // Only the selected lane may finish the command.
    always_comb done_hit = |hit;
endmodule

// File: rtl/cmdreg_top.sv
// Host command register: stores an accepted word and exposes the live flag.
// Assumes the host polls rd_data[0] and writes only whole 16-bit words.
module cmdreg_top
    import cmdreg_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int MAX_WAIT   = 10000,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              disp_valid,
    output logic [7:0]        disp_opcode,
    output logic [NUM_CH-1:0] disp_sel,
    input  logic [NUM_CH-1:0] ch_done,
    output logic [NUM_CH-1:0] ch_reset
);
    logic              cmd_ok;
    logic              is_reset;
    logic              accept;
    logic              busy;
    logic              done_hit;
    seq_state_t        state;
    logic [WORD_W-1:1] stored;

    cmdreg_decode #(.NUM_CH(NUM_CH)) u_dec (
        .word     (wr_data),
        .cmd_ok   (cmd_ok),
        .is_reset (is_reset)
    );

    // A write counts only when it is well formed and nothing is running.
    always_comb accept = wr_en && cmd_ok && !busy;

    cmdreg_seq #(.MAX_WAIT(MAX_WAIT), .RST_CYCLES(RST_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .is_reset (is_reset),
        .done_hit (done_hit),
        .state    (state),
        .busy     (busy)
    );

    cmdreg_fanout #(.NUM_CH(NUM_CH)) u_fan (
        .state    (state),
        .chan     (stored[CH_LSB +: CH_W]),
        .ch_done  (ch_done),
        .disp_sel (disp_sel),
        .ch_reset (ch_reset),
        .done_hit (done_hit)
    );

    // Hold the fields of the last accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) stored <= '0;
        else if (accept) stored <= wr_data[WORD_W-1:1];
    end

    // Present readback and the dispatch payload.
    always_comb begin
        rd_data     = {stored, busy};
        disp_valid  = (state == ST_ISSUE);
        disp_opcode = stored[OP_LSB +: OP_W];
    end
endmodule

// File: rtl/cmdreg_checker.sv
// Temporal checks on the command register ports, bound to cmdreg_top.
// Assumes the busy run never exceeds the larger of the two cycle limits.
module cmdreg_checker #(
    parameter int NUM_CH     = 4,
    parameter int MAX_WAIT   = 10000,
    parameter int RST_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [15:0]       rd_data,
    input logic              disp_valid,
    input logic [NUM_CH-1:0] disp_sel,
    input logic [NUM_CH-1:0] ch_reset
);
    localparam int BOUND = (MAX_WAIT > RST_CYCLES) ? MAX_WAIT : RST_CYCLES;
    localparam int RUN_W = $clog2(BOUND + 2);

    logic [RUN_W-1:0] busy_run;

    // Count consecutive cycles with the flag set, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= '0;
        else if (!rd_data[0]) busy_run <= '0;
        else if (busy_run != '1) busy_run <= busy_run + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (rd_data == 16'h0 && !disp_valid && ch_reset == '0)); // R1
    AST_STROBE_SINGLE: assert property (@(posedge clk) disp_valid |=> !disp_valid) else $error("strobe longer than one cycle"); // R3
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) disp_valid |-> $countones(disp_sel) == 1); // R3
    AST_SEL_ONLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !disp_valid |-> disp_sel == '0); // R3
    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) disp_valid |-> $past(wr_en && !rd_data[0])); // R5
    AST_RESET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (ch_reset != '0) |-> (!disp_valid && rd_data[0])); // R7
    AST_FLAG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) rd_data[0] |-> busy_run < RUN_W'(BOUND)); // R8
endmodule

bind cmdreg_top cmdreg_checker #(
    .NUM_CH     (NUM_CH),
    .MAX_WAIT   (MAX_WAIT),
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .disp_valid (disp_valid),
    .disp_sel   (disp_sel),
    .ch_reset   (ch_reset)
);

// File: tb/tb_cmdreg_top.sv
`timescale 1ns/1ps
module tb_cmdreg_top;
    localparam int NCH  = 4;
    localparam int MW   = 40;
    localparam int RSTC = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [15:0]    wr_data = 16'h0;
    logic [15:0]    rd_data;
    logic           disp_valid;
    logic [7:0]     disp_opcode;
    logic [NCH-1:0] disp_sel;
    logic [NCH-1:0] ch_done = '0;
    logic [NCH-1:0] ch_reset;

    int total = 0;
    int bad   = 0;

    cmdreg_top #(.NUM_CH(NCH), .MAX_WAIT(MW), .RST_CYCLES(RSTC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .disp_valid(disp_valid), .disp_opcode(disp_opcode),
        .disp_sel(disp_sel), .ch_done(ch_done), .ch_reset(ch_reset)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Returns at the falling edge of the cycle after the write edge.
    task automatic host_write(input logic [15:0] w);
        wr_en = 1'b1; wr_data = w;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0;
    endtask

    task automatic pulse_done(input int ch);
        ch_done = NCH'(1) << ch;
        @(posedge clk); @(negedge clk);
        ch_done = '0;
    endtask

    task automatic t_reset_state;
        chk("R1 rd_data", rd_data, 16'h0);
        chk("R1 disp_valid", disp_valid, 0);
        chk("R1 ch_reset", ch_reset, 0);
    endtask

    task automatic t_dispatch;
        host_write(16'hA521);
        chk("R3 strobe", disp_valid, 1);
        chk("R3 opcode", disp_opcode, 8'hA5);
        chk("R3 sel", disp_sel, 4'b0100);
        chk("R2 readback", rd_data, 16'hA521);
        @(negedge clk);
        chk("R3 strobe single", disp_valid, 0);
        pulse_done(1);
        chk("R4 other done ignored", rd_data, 16'hA521);
        pulse_done(2);
        chk("R4 flag cleared", rd_data, 16'hA520);
        // done given in the strobe cycle itself
        host_write(16'h3C01);
        chk("R3 sel ch0", disp_sel, 4'b0001);
        pulse_done(0);
        chk("R4 done in strobe cycle", rd_data, 16'h3C00);
        host_write(16'hFF31);
        chk("R3 sel ch3", disp_sel, 4'b1000);
        chk("R3 opcode ff", disp_opcode, 8'hFF);
        pulse_done(3);
        chk("R4 ch3 cleared", rd_data, 16'hFF30);
    endtask

    task automatic t_busy_write;
        host_write(16'h1111);
        @(negedge clk);
        host_write(16'h2201);
        chk("R5 no strobe while busy", disp_valid, 0);
        chk("R5 word kept", rd_data, 16'h1111);
        // write and completing done in the same cycle
        wr_en = 1'b1; wr_data = 16'h2201; ch_done = 4'b0010;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0; ch_done = '0;
        chk("R5 same-cycle write dropped", rd_data, 16'h1110);
        chk("R5 no strobe after collision", disp_valid, 0);
        @(negedge clk);
        chk("R5 still idle", {disp_valid, rd_data[0]}, 0);
    endtask

    task automatic t_invalid;
        host_write(16'h2205);
        chk("R6 reserved bit2", {disp_valid, rd_data}, {1'b0, 16'h1110});
        host_write(16'h2209);
        chk("R6 reserved bit3", {disp_valid, rd_data}, {1'b0, 16'h1110});
        host_write(16'h2210);
        chk("R6 flag zero", {disp_valid, rd_data}, {1'b0, 16'h1110});
        host_write(16'h2251);
        chk("R6 channel out of range", {disp_valid, rd_data}, {1'b0, 16'h1110});
        host_write(16'h0002);
        chk("R6 reset without flag", {ch_reset, rd_data}, {4'h0, 16'h1110});
    endtask

    task automatic t_reset_cmd(input logic [15:0] w);
        host_write(w);
        chk("R7 no strobe", disp_valid, 0);
        for (int k = 0; k < RSTC; k++) begin
            if (ch_reset !== 4'hF || rd_data[0] !== 1'b1)
                chk("R7 reset window", {ch_reset, rd_data[0]}, {4'hF, 1'b1});
            @(negedge clk);
        end
        chk("R7 reset released", ch_reset, 0);
        chk("R7 flag cleared", rd_data, w & 16'hFFFE);
    endtask

    task automatic t_timeout;
        host_write(16'h7731);
        for (int k = 1; k < MW; k++) @(negedge clk);
        chk("R8 busy before limit", rd_data[0], 1);
        @(negedge clk);
        chk("R8 cleared at limit", rd_data, 16'h7730);
        host_write(16'h0101);
        chk("R8 next write accepted", {disp_valid, disp_sel}, {1'b1, 4'b0001});
        pulse_done(0);
        chk("R8 next completes", rd_data, 16'h0100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state;
        rst_n = 1'b1;
        @(negedge clk);
        t_dispatch;
        t_busy_write;
        t_invalid;
        t_reset_cmd(16'h0003);
        t_reset_cmd(16'hFF93);
        t_timeout;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule